// File: doc/BRIEF.md
# Keyed-Write Watchdog Timer

This block is a watchdog timer built around an up-counter and a small control/status register. Both registers sit behind one shared write address. A write only reaches them when it is a full 16-bit transfer whose upper byte carries a key value. The key selects the target register, and the lower byte carries the data. This makes it very unlikely that a stray byte store, or a word store with random content, disturbs the timer.

While the run bit is set, the counter advances by one on each tick of a clock enable. The clock enable can optionally be divided by a simple prescaler. When the counter wraps from all ones to zero, the block raises its overflow flag and issues a one-cycle internal reset request. That request clears the timer on the following edge.

A companion system control byte holds a reset-source bit that software cannot write. The external reset pin sets it to 1, and a watchdog reset clears it to 0. The same byte also holds four ordinary read/write option bits. Software can therefore tell, after any restart, which cause produced the restart.

Top module: `wdt_keyed_top`

## Requirements
- R1: After the external reset is asserted (rst_ext_n low), the counter reads 0x00, the control/status register reads 0x00, the system byte reads 0x08 and rst_req is low.
- R2: A word write (bus_word=1) to the shared address 0x0 whose upper byte is 0x5A loads the lower byte into the counter and leaves the control/status register unchanged.
- R3: A word write to address 0x0 whose upper byte is 0xA5 loads bit 0 of the lower byte into the run bit (control/status bit 0). The other lower-byte bits have no effect.
- R4: A byte-sized write (bus_word=0) to address 0x0 changes neither the counter nor the control/status register, whatever its key.
- R5: A word write to address 0x0 with an upper byte other than 0x5A or 0xA5 changes no register. A keyed word write to the control/status read address 0x1 also changes no register.
- R6: With the run bit set, the counter increases by one at each clock edge where tick_en is high. It holds when tick_en is low or when the run bit is clear.
- R7: When the counter wraps from 0xFF to 0x00 on a tick, rst_req is high for exactly the next cycle. During that cycle the overflow flag (control/status bit 7) reads 1.
- R8: At the edge that ends the rst_req pulse, the counter and the control/status register are cleared, rst_src drops to 0 and the four option bits of the system byte are cleared.
- R9: The reset-source bit (system byte bit 3, also on rst_src) is set by the external reset. Software writes to the system byte never change it.
- R10: The system byte at address 0x2 accepts writes of either size. Only bits 5, 4, 2 and 1 are writable. Bits 7, 6 and 0 always read 0.
- R11: Reads are combinational. Address 0x0 returns the counter, address 0x1 returns the control/status register and address 0x2 returns the system byte, each zero-extended to 16 bits. Any other address returns 0.
- R12: A keyed counter load in the same cycle as a tick wins: the counter takes the written value and does not also increment.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_ext_n | input | 1 | External reset, active low, asynchronous |
| tick_en | input | 1 | Count enable from the clock divider |
| bus_addr | input | 4 | Register address |
| bus_wdata | input | 16 | Write data, key in the upper byte |
| bus_word | input | 1 | 1 = word transfer, 0 = byte transfer |
| bus_we | input | 1 | Write strobe |
| bus_rdata | output | 16 | Read data, zero-extended |
| rst_req | output | 1 | One-cycle internal reset request on overflow |
| rst_src | output | 1 | Reset-source bit: 1 external, 0 watchdog |

## Verification
The bench first walks keyed, unkeyed and byte-sized writes. A decoder that ignored the size strobe, or that compared only part of the key, would let those writes corrupt the counter. The bench then drives the counter through the 0xFF wrap. A design that held the request for more than one cycle, set the overflow flag late, or left the reset-source bit set after a watchdog reset would be caught at the exact cycles around the pulse. A load that collides with a tick must yield the written value and not that value plus one. Repeated writes to the system byte must leave the reset-source bit untouched.

// File: rtl/wdt_keyed_pkg.sv
package wdt_keyed_pkg;
   localparam int BYTE_W = 8;
   localparam logic [BYTE_W-1:0] KEY_CNT = 8'h5A;
   localparam logic [BYTE_W-1:0] KEY_CSR = 8'hA5;
   localparam int CSR_RUN = 0;
   localparam int CSR_OVF = 7;
   localparam int SYS_SRC = 3;
   localparam logic [BYTE_W-1:0] SYS_RW_MASK = 8'h36;

   typedef struct packed {
      logic              ld_cnt;
      logic              ld_csr;
      logic              ld_sys;
      logic [BYTE_W-1:0] val;
   } wr_cmd_t;
endpackage

// File: rtl/wdt_key_dec.sv
module wdt_key_dec
   import wdt_keyed_pkg::*;
#(
   parameter int ADDR_W   = 4,
   parameter int DATA_W   = 16,
   parameter int A_SHARED = 0,
   parameter int A_SYS    = 2
) (
   input  logic              we,
   input  logic              word,
   input  logic [ADDR_W-1:0] addr,
   input  logic [DATA_W-1:0] wdata,
   output wr_cmd_t           cmd
);
   localparam int KEY_LO = BYTE_W;
   localparam int KEY_HI = 2*BYTE_W - 1;

   logic [BYTE_W-1:0] key;
   logic              hit_shared;
   logic              hit_sys;
   logic              keyed_ok;

   always_comb begin
      key        = wdata[KEY_HI:KEY_LO];
      hit_shared = (addr == ADDR_W'(A_SHARED));
      hit_sys    = (addr == ADDR_W'(A_SYS));
      keyed_ok   = we & word & hit_shared;
      cmd.ld_cnt = keyed_ok & (key == KEY_CNT);
      cmd.ld_csr = keyed_ok & (key == KEY_CSR);
      cmd.ld_sys = we & hit_sys;
      cmd.val    = wdata[BYTE_W-1:0];
   end
endmodule

// File: rtl/wdt_tick_gen.sv
module wdt_tick_gen #(
   parameter int PRESCALE = 1
) (
   input  logic clk,
   input  logic rst_n,
   input  logic clr,
   input  logic tick_en,
   output logic tick
);
   generate
      if (PRESCALE == 1) begin : g_direct
         logic unused_direct;
         assign unused_direct = clk ^ rst_n ^ clr;
         assign tick = tick_en;
      end else begin : g_div
         localparam int PW = $clog2(PRESCALE);
         logic [PW-1:0] div_q;
         logic          last;
         assign last = (div_q == PW'(PRESCALE-1));
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n)        div_q <= '0;
            else if (clr)      div_q <= '0;
            else if (tick_en)  div_q <= last ? '0 : div_q + 1'b1;
         end
         assign tick = tick_en & last;
      end
   endgenerate
endmodule

// File: rtl/wdt_cnt_core.sv
module wdt_cnt_core
   import wdt_keyed_pkg::*;
#(
   parameter int CNT_W = 8
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              tick,
   input  wr_cmd_t           cmd,
   output logic [CNT_W-1:0]  cnt,
   output logic              run,
   output logic              ovf,
   output logic              rst_req
);
   localparam logic [CNT_W-1:0] CNT_MAX = {CNT_W{1'b1}};

   logic clr;
   logic step;
   logic wrap;

   assign clr  = rst_req;
   assign step = tick & run & ~cmd.ld_cnt & ~clr;
   assign wrap = step & (cnt == CNT_MAX);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)           cnt <= '0;
      else if (clr)         cnt <= '0;
      else if (cmd.ld_cnt)  cnt <= cmd.val[CNT_W-1:0];
      else if (step)        cnt <= cnt + 1'b1;
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         run <= 1'b0;
         ovf <= 1'b0;
      end else if (clr) begin
         run <= 1'b0;
         ovf <= 1'b0;
      end else begin
         if (cmd.ld_csr) run <= cmd.val[CSR_RUN];
         if (wrap)       ovf <= 1'b1;
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) rst_req <= 1'b0;
      else        rst_req <= wrap;
   end
endmodule

// File: rtl/wdt_sysctl.sv
module wdt_sysctl
   import wdt_keyed_pkg::*;
(
   input  logic              clk,
   input  logic              rst_n,
   input  logic              clr,
   input  wr_cmd_t           cmd,
   output logic [BYTE_W-1:0] sys_rd,
   output logic              src
);
   logic [BYTE_W-1:0] opt_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)          opt_q <= '0;
      else if (clr)        opt_q <= '0;
      else if (cmd.ld_sys) opt_q <= cmd.val & SYS_RW_MASK;
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)   src <= 1'b1;
      else if (clr) src <= 1'b0;
   end

   always_comb begin
      sys_rd          = opt_q & SYS_RW_MASK;
      sys_rd[SYS_SRC] = src;
   end
endmodule

// File: rtl/wdt_keyed_top.sv
module wdt_keyed_top
   import wdt_keyed_pkg::*;
#(
   parameter int ADDR_W   = 4,
   parameter int DATA_W   = 16,
   parameter int CNT_W    = 8,
   parameter int PRESCALE = 1,
   parameter int A_SHARED = 0,
   parameter int A_CSR    = 1,
   parameter int A_SYS    = 2
) (
   input  logic              clk,
   input  logic              rst_ext_n,
   input  logic              tick_en,
   input  logic [ADDR_W-1:0] bus_addr,
   input  logic [DATA_W-1:0] bus_wdata,
   input  logic              bus_word,
   input  logic              bus_we,
   output logic [DATA_W-1:0] bus_rdata,
   output logic              rst_req,
   output logic              rst_src
);
   localparam int RD_PAD = DATA_W - BYTE_W;

   generate
      if (CNT_W < 1 || CNT_W > BYTE_W) begin : g_bad_cnt
         $error("CNT_W must lie between 1 and the byte width");
      end
      if (DATA_W != 2*BYTE_W) begin : g_bad_data
         $error("DATA_W must hold exactly a key byte and a data byte");
      end
      if (PRESCALE < 1) begin : g_bad_pre
         $error("PRESCALE must be at least 1");
      end
      if (A_SHARED == A_CSR || A_SHARED == A_SYS || A_CSR == A_SYS) begin : g_bad_addr
         $error("register addresses must differ");
      end
   endgenerate

   wr_cmd_t           cmd;
   logic              tick_int;
   logic [CNT_W-1:0]  cnt_q;
   logic              run_q;
   logic              ovf_q;
   logic [BYTE_W-1:0] csr_rd;
   logic [BYTE_W-1:0] cnt_rd;
   logic [BYTE_W-1:0] sys_rd;
   logic [BYTE_W-1:0] rd_byte;

   wdt_key_dec #(
      .ADDR_W(ADDR_W), .DATA_W(DATA_W), .A_SHARED(A_SHARED), .A_SYS(A_SYS)
   ) u_dec (
      .we(bus_we), .word(bus_word), .addr(bus_addr), .wdata(bus_wdata), .cmd(cmd)
   );

   wdt_tick_gen #(.PRESCALE(PRESCALE)) u_tick (
      .clk(clk), .rst_n(rst_ext_n), .clr(rst_req), .tick_en(tick_en), .tick(tick_int)
   );

   wdt_cnt_core #(.CNT_W(CNT_W)) u_core (
      .clk(clk), .rst_n(rst_ext_n), .tick(tick_int), .cmd(cmd),
      .cnt(cnt_q), .run(run_q), .ovf(ovf_q), .rst_req(rst_req)
   );

   wdt_sysctl u_sys (
      .clk(clk), .rst_n(rst_ext_n), .clr(rst_req), .cmd(cmd),
      .sys_rd(sys_rd), .src(rst_src)
   );

   always_comb begin
      cnt_rd          = BYTE_W'(cnt_q);
      csr_rd          = '0;
      csr_rd[CSR_RUN] = run_q;
      csr_rd[CSR_OVF] = ovf_q;
      if (bus_addr == ADDR_W'(A_SHARED))   rd_byte = cnt_rd;
      else if (bus_addr == ADDR_W'(A_CSR)) rd_byte = csr_rd;
      else if (bus_addr == ADDR_W'(A_SYS)) rd_byte = sys_rd;
      else                                 rd_byte = '0;
      bus_rdata = {{RD_PAD{1'b0}}, rd_byte};
   end
endmodule

// File: rtl/wdt_keyed_chk.sv
module wdt_keyed_chk #(
   parameter int ADDR_W   = 4,
   parameter int DATA_W   = 16,
   parameter int CNT_W    = 8,
   parameter int A_SHARED = 0
) (
   input logic              clk,
   input logic              rst_n,
   input logic              we,
   input logic              word,
   input logic [ADDR_W-1:0] addr,
   input logic [DATA_W-1:0] wdata,
   input logic              tick,
   input logic [CNT_W-1:0]  cnt,
   input logic              run,
   input logic              ovf,
   input logic              rst_req,
   input logic              src
);
   logic at_shared;
   logic is_cnt_key;
   logic is_csr_key;
   assign at_shared  = (addr == ADDR_W'(A_SHARED));
   assign is_cnt_key = we & word & at_shared & (wdata[15:8] == 8'h5A);
   assign is_csr_key = we & word & at_shared & (wdata[15:8] == 8'hA5);

   p_load_cnt_r2: assert property (@(posedge clk) disable iff (!rst_n)
      (is_cnt_key && !rst_req) |=> (cnt == $past(wdata[CNT_W-1:0])));

   p_byte_ignored_r4: assert property (@(posedge clk) disable iff (!rst_n)
      (we && !word && at_shared && !rst_req && !(tick && run)) |=>
         ($stable(cnt) && $stable(run)));

   p_pulse_single_r7: assert property (@(posedge clk) disable iff (!rst_n)
      rst_req |=> !rst_req);

   p_wrap_pulse_r7: assert property (@(posedge clk) disable iff (!rst_n)
      (tick && run && (cnt == {CNT_W{1'b1}}) && !is_cnt_key && !rst_req) |=>
         (rst_req && ovf && cnt == '0));

   p_clear_after_r8: assert property (@(posedge clk) disable iff (!rst_n)
      rst_req |=> (cnt == '0 && !run && !ovf && !src));

   p_src_stable_r9: assert property (@(posedge clk) disable iff (!rst_n)
      !rst_req |=> $stable(src));

   p_load_priority_r12: assert property (@(posedge clk) disable iff (!rst_n)
      (is_cnt_key && tick && run && !rst_req) |=> (cnt == $past(wdata[CNT_W-1:0])));

   p_csr_key_r3: assert property (@(posedge clk) disable iff (!rst_n)
      (is_csr_key && !rst_req) |=> (run == $past(wdata[0])));
endmodule

bind wdt_keyed_top wdt_keyed_chk #(
   .ADDR_W(ADDR_W), .DATA_W(DATA_W), .CNT_W(CNT_W), .A_SHARED(A_SHARED)
) u_chk (
   .clk(clk), .rst_n(rst_ext_n), .we(bus_we), .word(bus_word), .addr(bus_addr),
   .wdata(bus_wdata), .tick(tick_int), .cnt(cnt_q), .run(run_q), .ovf(ovf_q),
   .rst_req(rst_req), .src(rst_src)
);

// File: tb/sim_wdt_keyed_top.sv
module sim_wdt_keyed_top;
   localparam int CLK_P = 10;

   logic        clk = 1'b0;
   logic        rst_ext_n = 1'b0;
   logic        tick_en = 1'b0;
   logic [3:0]  bus_addr = '0;
   logic [15:0] bus_wdata = '0;
   logic        bus_word = 1'b0;
   logic        bus_we = 1'b0;
   logic [15:0] bus_rdata;
   logic        rst_req;
   logic        rst_src;

   int n_chk = 0;
   int n_bad = 0;
   bit done = 1'b0;

   always #(CLK_P/2) clk = ~clk;

   wdt_keyed_top u0 (
      .clk(clk), .rst_ext_n(rst_ext_n), .tick_en(tick_en), .bus_addr(bus_addr),
      .bus_wdata(bus_wdata), .bus_word(bus_word), .bus_we(bus_we),
      .bus_rdata(bus_rdata), .rst_req(rst_req), .rst_src(rst_src)
   );

   // entry: addr[40:37] wdata[36:21] word[20] exp_cnt[19:12] exp_csr[11:4] tag[3:0]
   localparam logic [40:0] VEC [9] = '{
      {4'h0, 16'h5A3C, 1'b1, 8'h3C, 8'h00, 4'd2},  // R2 counter load
      {4'h0, 16'h5A77, 1'b0, 8'h3C, 8'h00, 4'd4},  // R4 byte write ignored
      {4'h0, 16'h1234, 1'b1, 8'h3C, 8'h00, 4'd5},  // R5 bad key
      {4'h0, 16'hA501, 1'b1, 8'h3C, 8'h01, 4'd3},  // R3 run set
      {4'h0, 16'h5AFF, 1'b0, 8'h3C, 8'h01, 4'd4},  // R4 byte with counter key
      {4'h0, 16'hA5FE, 1'b1, 8'h3C, 8'h00, 4'd3},  // R3 only bit 0 writable
      {4'h0, 16'hA501, 1'b0, 8'h3C, 8'h00, 4'd4},  // R4 byte with csr key
      {4'h1, 16'hA501, 1'b1, 8'h3C, 8'h00, 4'd5},  // R5 keyed write at read address
      {4'h0, 16'h5A00, 1'b1, 8'h00, 8'h00, 4'd2}   // R2 load zero
   };

   task automatic chk(input string tag, input logic [15:0] act, input logic [15:0] exp,
                      input string what);
      n_chk++;
      if (act !== exp) begin
         n_bad++;
         $display("FAIL %s %s: actual %h expected %h", tag, what, act, exp);
      end
   endtask

   task automatic wr(input logic [3:0] a, input logic [15:0] d, input logic w);
      @(negedge clk);
      bus_we = 1'b1; bus_addr = a; bus_wdata = d; bus_word = w;
      @(negedge clk);
      bus_we = 1'b0;
   endtask

   task automatic rd(input logic [3:0] a, output logic [15:0] d);
      bus_addr = a;
      #1;
      d = bus_rdata;
   endtask

   task automatic finish_run();
      if (!done) begin
         done = 1'b1;
         $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
         $finish;
      end
   endtask

   initial begin
      #(CLK_P*100000);
      n_chk++; n_bad++;
      $display("FAIL watchdog: actual hung expected finish");
      finish_run();
   end

   initial begin
      logic [15:0] d;
      repeat (3) @(negedge clk);
      rst_ext_n = 1'b1;
      @(negedge clk);
      // R1 reset state
      rd(4'h0, d); chk("R1", d, 16'h0000, "counter after reset");
      rd(4'h1, d); chk("R1", d, 16'h0000, "csr after reset");
      rd(4'h2, d); chk("R1", d, 16'h0008, "system byte after reset");
      chk("R1", {15'b0, rst_req}, 16'h0, "rst_req after reset");
      rd(4'h7, d); chk("R11", d, 16'h0000, "unmapped read");

      for (int i = 0; i < 9; i++) begin
         wr(VEC[i][40:37], VEC[i][36:21], VEC[i][20]);
         rd(4'h0, d); chk($sformatf("R%0d", VEC[i][3:0]), d, {8'h0, VEC[i][19:12]},
                          $sformatf("vector %0d counter", i));
         rd(4'h1, d); chk($sformatf("R%0d", VEC[i][3:0]), d, {8'h0, VEC[i][11:4]},
                          $sformatf("vector %0d csr", i));
      end

      // R10 / R9 system byte writes
      wr(4'h2, 16'h00FF, 1'b1);
      rd(4'h2, d); chk("R10", d, 16'h003E, "system byte all ones");
      wr(4'h2, 16'h00F7, 1'b0);
      rd(4'h2, d); chk("R9", d, 16'h003E, "source bit not writable");
      wr(4'h2, 16'h0000, 1'b0);
      rd(4'h2, d); chk("R9", d, 16'h0008, "byte write clears options only");

      // R6 counting
      wr(4'h0, 16'h5A10, 1'b1);
      wr(4'h0, 16'hA501, 1'b1);
      tick_en = 1'b1;
      repeat (5) @(negedge clk);
      tick_en = 1'b0;
      rd(4'h0, d); chk("R6", d, 16'h0015, "five ticks");
      repeat (3) @(negedge clk);
      rd(4'h0, d); chk("R6", d, 16'h0015, "hold without tick");
      wr(4'h0, 16'hA500, 1'b1);
      tick_en = 1'b1;
      repeat (4) @(negedge clk);
      tick_en = 1'b0;
      rd(4'h0, d); chk("R6", d, 16'h0015, "hold with run clear");

      // R12 load beats tick
      wr(4'h0, 16'hA501, 1'b1);
      @(negedge clk);
      bus_we = 1'b1; bus_addr = 4'h0; bus_wdata = 16'h5A40; bus_word = 1'b1; tick_en = 1'b1;
      @(negedge clk);
      bus_we = 1'b0; tick_en = 1'b0;
      rd(4'h0, d); chk("R12", d, 16'h0040, "load with tick");

      // R7 / R8 overflow
      wr(4'h2, 16'h00FF, 1'b1);
      wr(4'h0, 16'h5AFD, 1'b1);
      tick_en = 1'b1;
      @(negedge clk);
      @(negedge clk);
      rd(4'h0, d); chk("R7", d, 16'h00FF, "counter at max");
      chk("R7", {15'b0, rst_req}, 16'h0, "no pulse before wrap");
      @(negedge clk);
      tick_en = 1'b0;
      chk("R7", {15'b0, rst_req}, 16'h1, "pulse after wrap");
      rd(4'h1, d); chk("R7", d, 16'h0081, "overflow flag during pulse");
      rd(4'h0, d); chk("R7", d, 16'h0000, "counter wrapped");
      @(negedge clk);
      chk("R7", {15'b0, rst_req}, 16'h0, "pulse one cycle");
      rd(4'h1, d); chk("R8", d, 16'h0000, "csr cleared");
      rd(4'h2, d); chk("R8", d, 16'h0000, "system byte after watchdog reset");
      chk("R8", {15'b0, rst_src}, 16'h0, "rst_src after watchdog reset");
      wr(4'h2, 16'h00FF, 1'b1);
      rd(4'h2, d); chk("R9", d, 16'h0036, "source stays 0 under write");

      // R1 / R9 external reset again
      @(negedge clk);
      rst_ext_n = 1'b0;
      @(negedge clk);
      rst_ext_n = 1'b1;
      @(negedge clk);
      rd(4'h2, d); chk("R9", d, 16'h0008, "external reset sets source");
      chk("R1", {15'b0, rst_src}, 16'h1, "rst_src after external reset");

      finish_run();
   end
endmodule